// File: doc/BRIEF.md
# Pixel Write Coalescing Cache

This block takes a stream of single-pixel write requests, each an (x, y) coordinate with a colour, and turns them into accesses on a memory port whose words are 16 bits wide. A programmable base address, a raster width in pixels and a colour depth of 1, 2, 4 or 8 bits per pixel place each pixel at a word address and a bit position. Pixel 0 of a word sits in its most significant bits.

The block keeps exactly one memory word on chip. A pixel that falls in the held word is merged into it in a single clock, with no memory traffic. A pixel that falls elsewhere causes a miss. If the held word was modified, it is first written back to memory. The target word is then read, and the new pixel is merged into the returned data. When the request stream stays idle for a programmable number of cycles, the modified word is written back so that memory shows the finished drawing. Horizontal fills therefore pay for one read and one write per word, while vertical runs pay for them on almost every pixel.

Top module: `pix_coalesce_cache`

## Requirements
- R1: After reset the block accepts requests (`req_ready` high) and issues neither a memory read nor a memory write while no request arrives.
- R2: A pixel's word address is `cfg_base + ((y*cfg_width + x) << cfg_depth) / 16`. Its bit offset is the same product modulo 16.
- R3: Bits per pixel are `1 << cfg_depth`. A pixel at bit offset `o` occupies word bits `[15-o : 16-o-bpp]`, so pixel 0 is in the MSBs, and a merge leaves every other bit of the word unchanged.
- R4: Only the low `bpp` bits of `req_color` are written. Higher colour bits are discarded.
- R5: A request whose word is already held is accepted without any memory access. Such hits can be accepted on consecutive cycles.
- R6: A miss while the held word is unmodified issues one read of the target word in the accepting cycle and no write. With data returned one cycle later, the next request is accepted two cycles after the missing one.
- R7: A miss while the held word is modified writes that word back to its own address in the accepting cycle, then reads the new word in the next cycle.
- R8: A modified word is written back once the request input has been idle for `cfg_idle` consecutive cycles, and never earlier while the block remains idle.
- R9: All four depth codes (0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp) place and size pixels per R2 and R3.
- R10: For any mix of requests, read latencies and idle gaps, memory matches a per-pixel reference once the final write-back has occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | AW | Word address of pixel (0,0) |
| cfg_width | input | CW | Raster width in pixels |
| cfg_depth | input | 2 | Depth code, bpp = 1 << code |
| cfg_idle | input | IW | Idle cycles before write-back |
| req_valid | input | 1 | Pixel request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_x | input | XW | Pixel column |
| req_y | input | YW | Pixel row |
| req_color | input | 8 | Pixel colour (low bpp bits used) |
| mem_rd_req | output | 1 | Memory read strobe |
| mem_wr_req | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | WW | Memory write data |
| mem_rdata | input | WW | Memory read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
Four kinds of input pattern are used. Directed runs of adjacent pixels within one word separate the hit path from the miss path, using both read counts and acceptance spacing. A pixel that jumps to a new word while the held word is modified exposes the order of write-back and read, and the address each one uses. Single pixels at each depth code, with all colour bits set, show field placement and colour masking. Randomised horizontal runs, vertical runs and scattered points are mixed with random read latency and idle gaps. These are compared against a reference memory, which shows whether coalescing ever loses or misplaces a pixel when flushes and misses interleave.

// File: rtl/pix_cache_pkg.sv
`timescale 1ns/1ps
package pix_cache_pkg;

   typedef enum logic [1:0] {
      PC_RUN  = 2'd0,
      PC_READ = 2'd1,
      PC_FILL = 2'd2
   } pc_state_e;

   localparam int unsigned PC_MAX_BPP = 8;

   function automatic logic [3:0] pc_bpp(input logic [1:0] code);
      return 4'd1 << code;
   endfunction

endpackage

// File: rtl/pix_addr_gen.sv
`timescale 1ns/1ps
module pix_addr_gen
   import pix_cache_pkg::*;
#(
   parameter int AW = 16,
   parameter int XW = 11,
   parameter int YW = 11,
   parameter int CW = 11,
   parameter int WW = 16
) (
   input  logic [AW-1:0]          base,
   input  logic [CW-1:0]          width,
   input  logic [1:0]             depth,
   input  logic [XW-1:0]          x,
   input  logic [YW-1:0]          y,
   output logic [AW-1:0]          word_addr,
   output logic [$clog2(WW)-1:0]  bit_off
);
   localparam int OW = $clog2(WW);
   localparam int PW = YW + CW;
   localparam int LW = ((PW > XW) ? PW : XW) + 1;
   localparam int BW = LW + $clog2(PC_MAX_BPP);

   logic [LW-1:0] lin;
   logic [BW-1:0] bitpos;

   always_comb begin
      lin       = LW'(y) * LW'(width) + LW'(x);
      bitpos    = BW'(lin) << depth;
      word_addr = base + AW'(bitpos >> OW);
      bit_off   = bitpos[OW-1:0];
   end
endmodule

// File: rtl/pix_merge.sv
`timescale 1ns/1ps
module pix_merge
   import pix_cache_pkg::*;
#(
   parameter int WW = 16
) (
   input  logic [WW-1:0]          word_in,
   input  logic [$clog2(WW)-1:0]  bit_off,
   input  logic [1:0]             depth,
   input  logic [7:0]             color,
   output logic [WW-1:0]          word_out
);
   localparam int OW = $clog2(WW);
   localparam int SW = OW + 1;

   logic [3:0]    bpp;
   logic [7:0]    low_mask;
   logic [SW-1:0] shamt;
   logic [WW-1:0] fld_mask;
   logic [WW-1:0] fld_val;

   always_comb begin
      bpp      = pc_bpp(depth);
      low_mask = 8'((9'd1 << bpp) - 9'd1);
      shamt    = SW'(WW) - SW'(bpp) - SW'(bit_off);
      fld_mask = WW'(low_mask) << shamt;
      fld_val  = WW'(color & low_mask) << shamt;
   end

   for (genvar i = 0; i < WW; i++) begin : g_lane
      assign word_out[i] = fld_mask[i] ? fld_val[i] : word_in[i];
   end
endmodule

// File: rtl/pix_cache_ctrl.sv
`timescale 1ns/1ps
module pix_cache_ctrl
   import pix_cache_pkg::*;
#(
   parameter int AW = 16,
   parameter int WW = 16,
   parameter int IW = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IW-1:0]          cfg_idle,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic [AW-1:0]          req_addr,
   input  logic [$clog2(WW)-1:0]  req_off,
   input  logic [7:0]             req_color,
   output logic [WW-1:0]          mrg_word,
   output logic [$clog2(WW)-1:0]  mrg_off,
   output logic [7:0]             mrg_color,
   input  logic [WW-1:0]          mrg_result,
   output logic                   mem_rd_req,
   output logic                   mem_wr_req,
   output logic [AW-1:0]          mem_addr,
   output logic [WW-1:0]          mem_wdata,
   input  logic [WW-1:0]          mem_rdata,
   input  logic                   mem_rvalid
);
   localparam int OW = $clog2(WW);

   pc_state_e     st;
   logic [WW-1:0] c_word;
   logic [AW-1:0] c_tag;
   logic          c_valid;
   logic          c_dirty;
   logic [AW-1:0] p_addr;
   logic [OW-1:0] p_off;
   logic [7:0]    p_color;
   logic [IW-1:0] idle_cnt;

   logic hit, accept, flush;

   always_comb begin
      hit        = c_valid && (req_addr == c_tag);
      req_ready  = (st == PC_RUN);
      accept     = req_ready && req_valid;
      flush      = (st == PC_RUN) && !req_valid && c_dirty && (idle_cnt >= cfg_idle);
      mem_wr_req = (accept && !hit && c_dirty) || flush;
      mem_rd_req = (accept && !hit && !c_dirty) || (st == PC_READ);
      if (mem_wr_req)         mem_addr = c_tag;
      else if (st == PC_READ) mem_addr = p_addr;
      else                    mem_addr = req_addr;
      mem_wdata  = c_word;
      if (st == PC_FILL) begin
         mrg_word  = mem_rdata;
         mrg_off   = p_off;
         mrg_color = p_color;
      end else begin
         mrg_word  = c_word;
         mrg_off   = req_off;
         mrg_color = req_color;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= PC_RUN;
         c_word   <= '0;
         c_tag    <= '0;
         c_valid  <= 1'b0;
         c_dirty  <= 1'b0;
         p_addr   <= '0;
         p_off    <= '0;
         p_color  <= '0;
         idle_cnt <= '0;
      end else begin
         unique case (st)
            PC_RUN: begin
               if (accept) begin
                  if (hit) begin
                     c_word  <= mrg_result;
                     c_dirty <= 1'b1;
                  end else begin
                     p_addr  <= req_addr;
                     p_off   <= req_off;
                     p_color <= req_color;
                     c_valid <= 1'b0;
                     c_dirty <= 1'b0;
                     st      <= c_dirty ? PC_READ : PC_FILL;
                  end
               end else if (flush) begin
                  c_dirty <= 1'b0;
               end
            end
            PC_READ: st <= PC_FILL;
            PC_FILL: begin
               if (mem_rvalid) begin
                  c_word  <= mrg_result;
                  c_tag   <= p_addr;
                  c_valid <= 1'b1;
                  c_dirty <= 1'b1;
                  st      <= PC_RUN;
               end
            end
            default: st <= PC_RUN;
         endcase

         if (st != PC_RUN || req_valid || !c_dirty || flush) idle_cnt <= '0;
         else if (idle_cnt != '1)                             idle_cnt <= idle_cnt + 1'b1;
      end
   end

   // R5: a hit leaves the memory port quiet
   a_r5_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && hit) |-> (!mem_rd_req && !mem_wr_req));

   // R6: after a read strobe the block stalls for the data
   a_r6_read_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_req |=> !req_ready);

   // R7: the delayed read follows a write-back to another address
   a_r7_wb_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PC_READ) |-> ($past(mem_wr_req) && mem_addr != $past(mem_addr)));

   // R8: an idle write-back happens once, then the port stays quiet while idle
   a_r8_single_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_req && !req_valid) |=> (!mem_wr_req || req_valid || $past(req_valid)));

   // R10: read data only arrives while a fill is outstanding
   a_r10_rvalid_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> (st == PC_FILL));
endmodule

// File: rtl/pix_coalesce_cache.sv
`timescale 1ns/1ps
module pix_coalesce_cache
   import pix_cache_pkg::*;
#(
   parameter int AW = 16,
   parameter int XW = 11,
   parameter int YW = 11,
   parameter int CW = 11,
   parameter int WW = 16,
   parameter int IW = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  cfg_base,
   input  logic [CW-1:0]  cfg_width,
   input  logic [1:0]     cfg_depth,
   input  logic [IW-1:0]  cfg_idle,
   input  logic           req_valid,
   output logic           req_ready,
   input  logic [XW-1:0]  req_x,
   input  logic [YW-1:0]  req_y,
   input  logic [7:0]     req_color,
   output logic           mem_rd_req,
   output logic           mem_wr_req,
   output logic [AW-1:0]  mem_addr,
   output logic [WW-1:0]  mem_wdata,
   input  logic [WW-1:0]  mem_rdata,
   input  logic           mem_rvalid
);
   localparam int OW = $clog2(WW);

   if (WW < int'(PC_MAX_BPP) || (1 << OW) != WW) begin : g_bad_ww
      $error("pix_coalesce_cache: WW must be a power of two of at least 8");
   end
   if (AW < 1 || XW < 1 || YW < 1 || CW < 1 || IW < 1) begin : g_bad_w
      $error("pix_coalesce_cache: all widths must be positive");
   end

   logic [AW-1:0] a_addr;
   logic [OW-1:0] a_off;
   logic [WW-1:0] m_word, m_res;
   logic [OW-1:0] m_off;
   logic [7:0]    m_color;

   pix_addr_gen #(.AW(AW), .XW(XW), .YW(YW), .CW(CW), .WW(WW)) u_addr (
      .base      (cfg_base),
      .width     (cfg_width),
      .depth     (cfg_depth),
      .x         (req_x),
      .y         (req_y),
      .word_addr (a_addr),
      .bit_off   (a_off)
   );

   pix_merge #(.WW(WW)) u_merge (
      .word_in  (m_word),
      .bit_off  (m_off),
      .depth    (cfg_depth),
      .color    (m_color),
      .word_out (m_res)
   );

   pix_cache_ctrl #(.AW(AW), .WW(WW), .IW(IW)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_idle   (cfg_idle),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_addr   (a_addr),
      .req_off    (a_off),
      .req_color  (req_color),
      .mrg_word   (m_word),
      .mrg_off    (m_off),
      .mrg_color  (m_color),
      .mrg_result (m_res),
      .mem_rd_req (mem_rd_req),
      .mem_wr_req (mem_wr_req),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .mem_rvalid (mem_rvalid)
   );

   // R1: the port never reads and writes in the same cycle
   a_r1_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd_req && mem_wr_req));
endmodule

// File: tb/test_pix_coalesce_cache.sv
`timescale 1ns/1ps
module test_pix_coalesce_cache;
   localparam int AW = 16, XW = 11, YW = 11, CW = 11, WW = 16, IW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cfg_base = '0;
   logic [CW-1:0] cfg_width = 11'd40;
   logic [1:0]    cfg_depth = 2'd2;
   logic [IW-1:0] cfg_idle = 8'd5;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [XW-1:0] req_x = '0;
   logic [YW-1:0] req_y = '0;
   logic [7:0]    req_color = '0;
   logic          mem_rd_req, mem_wr_req;
   logic [AW-1:0] mem_addr;
   logic [WW-1:0] mem_wdata;
   logic [WW-1:0] mem_rdata;
   logic          mem_rvalid;

   always #5 clk = ~clk;

   pix_coalesce_cache #(.AW(AW), .XW(XW), .YW(YW), .CW(CW), .WW(WW), .IW(IW)) i_pix_coalesce_cache (
      .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_width(cfg_width),
      .cfg_depth(cfg_depth), .cfg_idle(cfg_idle), .req_valid(req_valid),
      .req_ready(req_ready), .req_x(req_x), .req_y(req_y), .req_color(req_color),
      .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
   );

   // memory model
   logic [15:0] mem    [0:4095];
   logic [15:0] shadow [0:4095];
   int          lat_max = 0;
   int          pend = 0, wlat = 0;
   logic [11:0] paddr;
   int          rd_cnt = 0, wr_cnt = 0, mcyc = 0;
   int          last_rd_cyc = 0, last_wr_cyc = 0;
   logic [15:0] last_rd_addr = '0, last_wr_addr = '0;

   always @(posedge clk) begin
      mcyc++;
      mem_rvalid <= 1'b0;
      if (mem_wr_req) begin
         mem[mem_addr[11:0]] = mem_wdata;
         wr_cnt++;
         last_wr_addr = mem_addr;
         last_wr_cyc  = mcyc;
      end
      if (mem_rd_req) begin
         rd_cnt++;
         last_rd_addr = mem_addr;
         last_rd_cyc  = mcyc;
         paddr = mem_addr[11:0];
         pend  = 1;
         wlat  = (lat_max == 0) ? 0 : int'($urandom % (lat_max + 1));
      end
      if (pend != 0) begin
         if (wlat == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= mem[paddr];
            pend = 0;
         end else wlat--;
      end
   end

   int n_chk = 0, n_fail = 0;
   int acc_cyc = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic void ref_put(input int x, input int y, input int c);
      int bpp, lin, bits, a, off, sh, m;
      bpp  = 1 << cfg_depth;
      lin  = y * int'(cfg_width) + x;
      bits = lin * bpp;
      a    = (int'(cfg_base) + bits / 16) & 4095;
      off  = bits % 16;
      sh   = 16 - bpp - off;
      m    = ((1 << bpp) - 1) << sh;
      shadow[a] = 16'((int'(shadow[a]) & ~m) | ((c & ((1 << bpp) - 1)) << sh));
   endfunction

   task automatic send(input int x, input int y, input int c);
      @(negedge clk);
      req_x = XW'(x); req_y = YW'(y); req_color = 8'(c); req_valid = 1'b1;
      forever begin
         #1;
         if (req_ready) begin
            @(posedge clk);
            #1 acc_cyc = mcyc;
            break;
         end
         @(negedge clk);
      end
      ref_put(x, y, c);
   endtask

   task automatic drop();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      drop();
      repeat (n) @(negedge clk);
   endtask

   int a0, a1, a2, a3, r0, w0;

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 4096; i++) begin mem[i] = '0; shadow[i] = '0; end
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (2) @(negedge clk);
      #1;
      chk("R1 ready after reset", 32'(req_ready), 32'd1);
      chk("R1 no traffic after reset", 32'(rd_cnt + wr_cnt), 32'd0);

      // base 100, width 40, 4 bpp, idle 5
      cfg_base = 16'd100; cfg_width = 11'd40; cfg_depth = 2'd2; cfg_idle = 8'd5;
      send(7, 3, 8'hF9); a0 = acc_cyc;
      chk("R2 read address", 32'(last_rd_addr), 32'd131);
      chk("R6 one read no write", 32'(rd_cnt * 16 + wr_cnt), 32'd16);
      send(4, 3, 1); a1 = acc_cyc;
      send(5, 3, 2); a2 = acc_cyc;
      send(6, 3, 3); a3 = acc_cyc;
      chk("R6 miss spacing", 32'(a1 - a0), 32'd2);
      chk("R5 hits back to back", 32'((a2 - a1) * 16 + (a3 - a2)), 32'h11);
      chk("R5 hits no reads", 32'(rd_cnt), 32'd1);
      w0 = wr_cnt;
      drop();
      repeat (5) @(posedge clk);
      #1 chk("R8 no early write-back", 32'(wr_cnt - w0), 32'd0);
      @(posedge clk);
      #1 chk("R8 write-back at idle count", 32'(wr_cnt - w0), 32'd1);
      chk("R3 R4 merged word", 32'(mem[131]), 32'h1239);

      // dirty miss ordering
      idle(4);
      send(8, 3, 5);
      send(0, 4, 8'h3C);
      chk("R7 write-back address", 32'(last_wr_addr), 32'd132);
      idle(3);
      chk("R7 read address", 32'(last_rd_addr), 32'd140);
      chk("R7 read follows write", 32'(last_rd_cyc - last_wr_cyc), 32'd1);
      idle(20);
      chk("R7 old word stored", 32'(mem[132]), 32'h5000);
      chk("R4 masked colour", 32'(mem[140]), 32'hC000);

      // depth modes
      cfg_base = 16'd512; cfg_width = 11'd64;
      cfg_depth = 2'd0;
      send(0, 0, 8'hFF); send(15, 0, 8'h01); idle(20);
      chk("R9 1bpp", 32'(mem[512]), 32'h8001);
      cfg_depth = 2'd1;
      send(5, 1, 8'hFF); idle(20);
      chk("R9 2bpp", 32'(mem[520]), 32'h0030);
      cfg_depth = 2'd2;
      send(1, 2, 8'hFE); idle(20);
      chk("R9 4bpp", 32'(mem[544]), 32'h0E00);
      cfg_depth = 2'd3;
      send(1, 2, 8'hA5); idle(20);
      chk("R9 8bpp", 32'(mem[576]), 32'h00A5);

      // randomised rounds
      for (int rnd = 0; rnd < 20; rnd++) begin
         int mism;
         cfg_depth = 2'($urandom % 4);
         cfg_width = 11'(16 + $urandom % 49);
         cfg_base  = 16'($urandom % 1500);
         cfg_idle  = 8'($urandom % 16);
         lat_max   = int'($urandom % 3);
         for (int k = 0; k < 24; k++) begin
            int kind, x0, y0, len;
            kind = int'($urandom % 3);
            x0   = int'($urandom % cfg_width);
            y0   = int'($urandom % 32);
            len  = 1 + int'($urandom % 12);
            if (kind == 0)
               for (int j = 0; j < len; j++) send((x0 + j) % int'(cfg_width), y0, int'($urandom % 256));
            else if (kind == 1)
               for (int j = 0; j < len; j++) send(x0, (y0 + j) % 32, int'($urandom % 256));
            else
               send(x0, y0, int'($urandom % 256));
            if ($urandom % 3 == 0) idle(int'($urandom % 20));
         end
         idle(60);
         mism = 0;
         for (int i = 0; i < 4096; i++) if (mem[i] !== shadow[i]) mism++;
         chk("R10 memory matches reference", 32'(mism), 32'd0);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule